// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data ports, A and B. Each port is modelled as three signals: an input bus, an output bus and a drive-enable bit for each group. The enable stands in for the three-state control of a pad. There is one capture register on each side. The A register stores the A port and the B register stores the B port. Each register has its own load strobe, so the two directions are clocked separately.

Each direction has its own source select. When a port is driven, it shows either the live value of the opposite port, passed through combinationally, or the value held in the opposite side's register. An active-low enable and a direction bit decide which port is driven, if either one is. When the enable is high, both ports are isolated, and both registers can still capture.

The data path is cut into independent groups, by default two groups of eight bits. Each group has its own enable, direction, two load strobes and two source selects. Both registers clear on a synchronous active-low reset.

Top module: `bxcv_top`

## Requirements
- R1: On a rising `clk` edge with `rst_n` high and `ld_a[g]` set, the A register of group g stores `a_din` of that group. With `ld_a[g]` clear, it keeps its value.
- R2: On a rising `clk` edge with `rst_n` high and `ld_b[g]` set, the B register of group g stores `b_din` of that group. With `ld_b[g]` clear, it keeps its value.
- R3: Capture into either register does not depend on `en_n` or `to_b`. This includes isolation, when `en_n[g]` is 1.
- R4: When `en_n[g]` is 1, both `a_drv[g]` and `b_drv[g]` are 0, and both group-g output slices are zero.
- R5: When `en_n[g]` is 0 and `to_b[g]` is 1, `b_drv[g]` is 1 and `a_drv[g]` is 0. The two enables are never 1 together.
- R6: When `en_n[g]` is 0 and `to_b[g]` is 0, `a_drv[g]` is 1 and `b_drv[g]` is 0.
- R7: While B is driven and `b_src_reg[g]` is 0, the group-g slice of `b_dout` equals the same slice of `a_din`, in the same cycle.
- R8: While B is driven and `b_src_reg[g]` is 1, `b_dout` shows the A register. A load made while this is selected appears in the cycle after the load edge.
- R9: While A is driven, `a_dout` shows the live `b_din` when `a_src_reg[g]` is 0 and the B register when it is 1.
- R10: Each group works only from its own control bits. Two groups may drive in opposite directions at the same time.
- R11: While `rst_n` is 0 at a rising edge, both registers of every group clear to zero, whatever the load strobes are.
- R12: An output slice whose drive-enable is 0 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Synchronous active-low reset of both registers |
| en_n | input | GROUPS | Active-low output enable, one bit per group |
| to_b | input | GROUPS | Direction: 1 drives B, 0 drives A |
| ld_a | input | GROUPS | Load strobe of the A register |
| ld_b | input | GROUPS | Load strobe of the B register |
| b_src_reg | input | GROUPS | Source for B: 0 live A, 1 stored A |
| a_src_reg | input | GROUPS | Source for A: 0 live B, 1 stored B |
| a_din | input | GROUPS*GRP_W | Value seen on port A |
| a_dout | output | GROUPS*GRP_W | Value driven onto port A |
| a_drv | output | GROUPS | Drive enable of port A |
| b_din | input | GROUPS*GRP_W | Value seen on port B |
| b_dout | output | GROUPS*GRP_W | Value driven onto port B |
| b_drv | output | GROUPS | Drive enable of port B |

## Verification
Drive enables, zero gating and the live pass-through take effect in the same cycle as their inputs. The bench changes inputs at the falling edge and samples them one nanosecond later. A register load becomes visible on a stored-source output one cycle later, at the next rising edge. The bench model updates its copies of the registers only after that edge, so a stored-mode check made in the load cycle still expects the old value, and the check in the following cycle expects the new one.

// File: rtl/bxcv_pkg.sv
package bxcv_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_e;

   function automatic logic drive_on(input logic en_n, input logic want_b, input logic side_b);
      return !en_n && (want_b == side_b);
   endfunction
endpackage

// File: rtl/bxcv_store.sv
module bxcv_store #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (ld)
         q <= d;
   end
endmodule

// File: rtl/bxcv_path.sv
module bxcv_path
   import bxcv_pkg::*;
#(
   parameter int W         = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  src_e         src,
   input  logic         drv,
   input  logic [W-1:0] live,
   input  logic [W-1:0] stored,
   output logic [W-1:0] dout
);
   logic [W-1:0] picked;

   always_comb picked = (src == SRC_STORED) ? stored : live;

   generate
      if (IDLE_ZERO) begin : g_gate
         always_comb dout = drv ? picked : '0;
      end else begin : g_pass
         logic unused_drv;
         always_comb unused_drv = drv;
         always_comb dout = picked;
      end
   endgenerate
endmodule

// File: rtl/bxcv_group.sv
module bxcv_group
   import bxcv_pkg::*;
#(
   parameter int W         = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_n,
   input  logic         to_b,
   input  logic         ld_a,
   input  logic         ld_b,
   input  logic         b_src_reg,
   input  logic         a_src_reg,
   input  logic [W-1:0] a_din,
   input  logic [W-1:0] b_din,
   output logic [W-1:0] a_dout,
   output logic [W-1:0] b_dout,
   output logic         a_drv,
   output logic         b_drv
);
   logic [W-1:0] reg_a, reg_b;

   bxcv_store #(.W(W)) u_store_a (
      .clk(clk), .rst_n(rst_n), .ld(ld_a), .d(a_din), .q(reg_a)
   );
   bxcv_store #(.W(W)) u_store_b (
      .clk(clk), .rst_n(rst_n), .ld(ld_b), .d(b_din), .q(reg_b)
   );

   always_comb begin
      b_drv = drive_on(en_n, to_b, 1'b1);
      a_drv = drive_on(en_n, to_b, 1'b0);
   end

   bxcv_path #(.W(W), .IDLE_ZERO(IDLE_ZERO)) u_to_b (
      .src(src_e'(b_src_reg)), .drv(b_drv), .live(a_din), .stored(reg_a), .dout(b_dout)
   );
   bxcv_path #(.W(W), .IDLE_ZERO(IDLE_ZERO)) u_to_a (
      .src(src_e'(a_src_reg)), .drv(a_drv), .live(b_din), .stored(reg_b), .dout(a_dout)
   );
endmodule

// File: rtl/bxcv_top.sv
module bxcv_top #(
   parameter int GROUPS    = 2,
   parameter int GRP_W     = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [GROUPS-1:0]       en_n,
   input  logic [GROUPS-1:0]       to_b,
   input  logic [GROUPS-1:0]       ld_a,
   input  logic [GROUPS-1:0]       ld_b,
   input  logic [GROUPS-1:0]       b_src_reg,
   input  logic [GROUPS-1:0]       a_src_reg,
   input  logic [GROUPS*GRP_W-1:0] a_din,
   output logic [GROUPS*GRP_W-1:0] a_dout,
   output logic [GROUPS-1:0]       a_drv,
   input  logic [GROUPS*GRP_W-1:0] b_din,
   output logic [GROUPS*GRP_W-1:0] b_dout,
   output logic [GROUPS-1:0]       b_drv
);
   localparam int DATA_W = GROUPS * GRP_W;

   generate
      if (GROUPS < 1) begin : g_bad_groups
         $error("bxcv_top: GROUPS must be at least 1");
      end
      if (GRP_W < 1 || DATA_W > 1024) begin : g_bad_width
         $error("bxcv_top: GRP_W out of range");
      end
   endgenerate

   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         bxcv_group #(.W(GRP_W), .IDLE_ZERO(IDLE_ZERO)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_n      (en_n[g]),
            .to_b      (to_b[g]),
            .ld_a      (ld_a[g]),
            .ld_b      (ld_b[g]),
            .b_src_reg (b_src_reg[g]),
            .a_src_reg (a_src_reg[g]),
            .a_din     (a_din[g*GRP_W +: GRP_W]),
            .b_din     (b_din[g*GRP_W +: GRP_W]),
            .a_dout    (a_dout[g*GRP_W +: GRP_W]),
            .b_dout    (b_dout[g*GRP_W +: GRP_W]),
            .a_drv     (a_drv[g]),
            .b_drv     (b_drv[g])
         );
      end
   endgenerate
endmodule

// File: rtl/bxcv_chk.sv
module bxcv_chk #(
   parameter int GROUPS = 2,
   parameter int GRP_W  = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [GROUPS-1:0]       en_n,
   input logic [GROUPS-1:0]       to_b,
   input logic [GROUPS-1:0]       ld_a,
   input logic [GROUPS-1:0]       ld_b,
   input logic [GROUPS-1:0]       b_src_reg,
   input logic [GROUPS-1:0]       a_src_reg,
   input logic [GROUPS*GRP_W-1:0] a_din,
   input logic [GROUPS*GRP_W-1:0] a_dout,
   input logic [GROUPS-1:0]       a_drv,
   input logic [GROUPS*GRP_W-1:0] b_din,
   input logic [GROUPS*GRP_W-1:0] b_dout,
   input logic [GROUPS-1:0]       b_drv
);
   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_chk
         p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_drv[g] && b_drv[g]));

         p_iso_r4: assert property (@(posedge clk) disable iff (!rst_n)
            en_n[g] |-> (!a_drv[g] && !b_drv[g] &&
                         a_dout[g*GRP_W +: GRP_W] == '0 && b_dout[g*GRP_W +: GRP_W] == '0));

         p_dir_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_n[g] && !to_b[g]) |-> a_drv[g]);

         p_live_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_n[g] && to_b[g] && !b_src_reg[g]) |->
               b_dout[g*GRP_W +: GRP_W] == a_din[g*GRP_W +: GRP_W]);

         p_live_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_n[g] && !to_b[g] && !a_src_reg[g]) |->
               a_dout[g*GRP_W +: GRP_W] == b_din[g*GRP_W +: GRP_W]);

         p_store_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ld_a[g] |=> ((!en_n[g] && to_b[g] && b_src_reg[g]) ->
               b_dout[g*GRP_W +: GRP_W] == $past(a_din[g*GRP_W +: GRP_W])));

         p_hold_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!ld_a[g] && !en_n[g] && to_b[g] && b_src_reg[g]) |=>
               ((!en_n[g] && to_b[g] && b_src_reg[g]) ->
                  b_dout[g*GRP_W +: GRP_W] == $past(b_dout[g*GRP_W +: GRP_W])));

         p_store_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ld_b[g] |=> ((!en_n[g] && !to_b[g] && a_src_reg[g]) ->
               a_dout[g*GRP_W +: GRP_W] == $past(b_din[g*GRP_W +: GRP_W])));
      end
   endgenerate
endmodule

bind bxcv_top bxcv_chk #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_n(en_n), .to_b(to_b), .ld_a(ld_a), .ld_b(ld_b),
   .b_src_reg(b_src_reg), .a_src_reg(a_src_reg), .a_din(a_din), .a_dout(a_dout),
   .a_drv(a_drv), .b_din(b_din), .b_dout(b_dout), .b_drv(b_drv)
);

// File: tb/bxcv_top_tb.sv
`timescale 1ns/1ps
module bxcv_top_tb;
   localparam int G = 2;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [G-1:0] en_n = '1, to_b = '0, ld_a = '0, ld_b = '0, b_src_reg = '0, a_src_reg = '0;
   logic [G*W-1:0] a_din = '0, b_din = '0;
   logic [G*W-1:0] a_dout, b_dout;
   logic [G-1:0]   a_drv, b_drv;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] m_ra [G];
   logic [W-1:0] m_rb [G];

   always #2.5 clk = ~clk;

   bxcv_top #(.GROUPS(G), .GRP_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .en_n(en_n), .to_b(to_b), .ld_a(ld_a), .ld_b(ld_b),
      .b_src_reg(b_src_reg), .a_src_reg(a_src_reg), .a_din(a_din), .a_dout(a_dout),
      .a_drv(a_drv), .b_din(b_din), .b_dout(b_dout), .b_drv(b_drv)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] exp_b(input int g);
      if (en_n[g] || !to_b[g]) return '0;
      return b_src_reg[g] ? m_ra[g] : a_din[g*W +: W];
   endfunction

   function automatic logic [W-1:0] exp_a(input int g);
      if (en_n[g] || to_b[g]) return '0;
      return a_src_reg[g] ? m_rb[g] : b_din[g*W +: W];
   endfunction

   task automatic check_all(input string tag);
      for (int g = 0; g < G; g++) begin
         string td, tb, ta;
         td = en_n[g] ? "R4" : (to_b[g] ? "R5" : "R6");
         tb = en_n[g] ? "R4" : (!to_b[g] ? "R12" : (b_src_reg[g] ? "R8" : "R7"));
         ta = en_n[g] ? "R4" : (to_b[g] ? "R12" : "R9");
         if (tag != "") begin tb = tag; ta = tag; end
         chk(td, W'(b_drv[g]), W'(!en_n[g] && to_b[g]));
         chk(td, W'(a_drv[g]), W'(!en_n[g] && !to_b[g]));
         chk(tb, b_dout[g*W +: W], exp_b(g));
         chk(ta, a_dout[g*W +: W], exp_a(g));
      end
   endtask

   task automatic step(input string tag);
      #1;
      check_all(tag);
      @(posedge clk);
      for (int g = 0; g < G; g++) begin
         if (!rst_n) begin
            m_ra[g] = '0; m_rb[g] = '0;
         end else begin
            if (ld_a[g]) m_ra[g] = a_din[g*W +: W];
            if (ld_b[g]) m_rb[g] = b_din[g*W +: W];
         end
      end
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int g = 0; g < G; g++) begin m_ra[g] = 'x; m_rb[g] = 'x; end
      @(negedge clk);
      // R11: reset clears registers even with loads requested
      rst_n = 0; en_n = '1; ld_a = '1; ld_b = '1; a_din = 16'hA55A; b_din = 16'h3CC3;
      repeat (3) step("");
      rst_n = 1; ld_a = '0; ld_b = '0; en_n = '0; to_b = 2'b01;
      b_src_reg = '1; a_src_reg = '1;
      step("R11");
      // R3: capture while isolated
      en_n = '1; ld_a = '1; ld_b = '1; a_din = 16'h1E2D; b_din = 16'h4B69;
      step("R3");
      ld_a = '0; ld_b = '0; a_din = 16'hFFFF; b_din = 16'hFFFF;
      en_n = '0; to_b = '1; b_src_reg = '1;
      step("R1");
      to_b = '0; a_src_reg = '1;
      step("R2");
      // R8: load while stored source selected, visible next cycle
      to_b = '1; b_src_reg = '1; ld_a = '1; a_din = 16'h7788;
      step("R8");
      ld_a = '0; a_din = 16'h0102;
      step("R8");
      // R10: groups driving in opposite directions
      to_b = 2'b10; b_src_reg = '0; a_src_reg = '0; a_din = 16'hC0DE; b_din = 16'hBEEF;
      step("R10");
      to_b = 2'b01; b_src_reg = 2'b01; a_src_reg = 2'b10; ld_b = 2'b10;
      step("R10");
      ld_b = '0;
      // Random mix
      for (int i = 0; i < 400; i++) begin
         en_n = G'($urandom); to_b = G'($urandom); ld_a = G'($urandom); ld_b = G'($urandom);
         b_src_reg = G'($urandom); a_src_reg = G'($urandom);
         a_din = (G*W)'($urandom); b_din = (G*W)'($urandom);
         if (($urandom % 4) == 0) en_n = '1;
         step("");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule